// File: doc/BRIEF.md
# Programmable Priority Interrupt Resolver

The block takes a snapshot of a 40-bit masked pending vector, a 40-bit class-steering vector and a table of 40 programmable priority slots. From these it finds two winners. One is the highest-ranked active source in the fast-interrupt (FIQ) class. The other is the highest-ranked active source in the normal-interrupt (IRQ) class. Both winners are reported in one packed 32-bit status word, which fits a read-only register. Rank does not come from a source's bit index. Slot 0 is the highest rank, and each slot names the source that holds that rank.

Resolution runs over several cycles. A start pulse captures all inputs. The scanner then checks a fixed number of slots per cycle, beginning at slot 0. When the scan is complete, it updates the status word and raises a one-cycle done strobe. The status word keeps its value until the next scan completes. Mask logic and slot storage are outside the block, so the pending vector arrives already masked.

Top module: `prio_resolver`

## Requirements
- R1: A start pulse while idle captures pend_i, level_i and slot_i. busy_o rises on the next cycle. The result appears on status_o together with a done_o pulse exactly ceil(NUM_SLOT/LANES) cycles after the capturing edge (10 with the defaults). Input changes after the capture have no effect on that result.
- R2: Each 32-bit slot word has a valid flag at bit 31 and a source ID at bits 5:0. All other slot bits are ignored. A slot is skipped when its valid flag is 0 or its ID is NUM_SRC (40) or more.
- R3: A source is active for FIQ when its pending bit and its level bit are both 1. It is active for IRQ when its pending bit is 1 and its level bit is 0.
- R4: Within each class, the lowest-numbered valid slot that names an active source wins. Two slots naming the same source are both evaluated, and the lower one decides the result.
- R5: Status layout: bit 15 is the FIQ valid flag and bits 5:0 hold the FIQ winner ID. Bit 31 is the IRQ valid flag and bits 21:16 hold the IRQ winner ID. All other bits read 0.
- R6: A class with no winner reads valid=0 with ID 0x3F. After reset, and whenever neither class has a winner, status_o is 0x003F003F.
- R7: done_o is high for exactly one cycle per scan. status_o changes only in a cycle where done_o is high.
- R8: A start pulse while busy_o is high is ignored. It neither restarts the scan nor produces an extra done pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Capture inputs and begin a scan (used only when idle) |
| pend_i | input | NUM_SRC | Masked pending vector, one bit per source |
| level_i | input | NUM_SRC | Class steering: 1 selects FIQ, 0 selects IRQ |
| slot_i | input | NUM_SLOT*32 | Slot table; slot s occupies bits s*32+31 : s*32 |
| busy_o | output | 1 | Scan in progress |
| done_o | output | 1 | One-cycle pulse when status_o has been updated |
| status_o | output | 32 | Packed FIQ and IRQ winners |

## Verification
The bench targets several corner cases:
- Slots that must be skipped, such as a cleared valid flag or an ID of 40 or 63. A resolver that ignores the valid flag or the range check would report a nonexistent or unintended source.
- Reversed and duplicated slot tables. A resolver that ranks by bit index or lets the last match overwrite would return the wrong winner in these tables.
- Garbage in unused slot bits. A resolver that decodes a wider ID field would misread these slots.
- Input changes and extra start pulses while a scan is running. A design that fails to capture, or that restarts, would report the scrambled inputs or an early or extra done pulse.

// File: rtl/prio_pkg.sv
package prio_pkg;
    localparam int SLOT_W       = 32;
    localparam int SLOT_VLD_BIT = 31;
    localparam int ID_W         = 6;
    localparam int STATUS_W     = 32;
    localparam int FIQ_VLD_BIT  = 15;
    localparam int IRQ_VLD_BIT  = 31;
    localparam int IRQ_ID_LSB   = 16;
    localparam logic [ID_W-1:0]     NO_ID       = '1;
    localparam logic [STATUS_W-1:0] IDLE_STATUS = 32'h003F_003F;

    function automatic logic [STATUS_W-1:0] pack_status(
        input logic            fiq_v,
        input logic [ID_W-1:0] fiq_id,
        input logic            irq_v,
        input logic [ID_W-1:0] irq_id
    );
        logic [STATUS_W-1:0] w;
        w = '0;
        w[FIQ_VLD_BIT]            = fiq_v;
        w[ID_W-1:0]               = fiq_id;
        w[IRQ_VLD_BIT]            = irq_v;
        w[IRQ_ID_LSB +: ID_W]     = irq_id;
        return w;
    endfunction
endpackage

// File: rtl/prio_slot_eval.sv
module prio_slot_eval
    import prio_pkg::*;
#(
    parameter int NUM_SRC = 40
) (
    input  logic               vld_i,
    input  logic [ID_W-1:0]    id_i,
    input  logic [NUM_SRC-1:0] pend_i,
    input  logic [NUM_SRC-1:0] level_i,
    output logic               fiq_hit_o,
    output logic               irq_hit_o
);
    localparam int ID_SPACE = 2 ** ID_W;
    localparam logic [ID_W:0] LIMIT = (ID_W+1)'(NUM_SRC);

    logic [ID_SPACE-1:0] pend_x;
    logic [ID_SPACE-1:0] level_x;
    logic                in_range;
    logic                live;

    always_comb begin
        pend_x    = ID_SPACE'(pend_i);
        level_x   = ID_SPACE'(level_i);
        in_range  = ({1'b0, id_i} < LIMIT);
        live      = vld_i & in_range & pend_x[id_i];
        fiq_hit_o = live &  level_x[id_i];
        irq_hit_o = live & ~level_x[id_i];
    end
endmodule

// File: rtl/prio_lane_pick.sv
module prio_lane_pick
    import prio_pkg::*;
#(
    parameter int LANES = 4
) (
    input  logic [LANES-1:0]           hit_i,
    input  logic [LANES-1:0][ID_W-1:0] id_i,
    output logic                       any_o,
    output logic [ID_W-1:0]            id_o
);
    always_comb begin
        any_o = |hit_i;
        id_o  = NO_ID;
        for (int l = LANES - 1; l >= 0; l--) begin
            if (hit_i[l]) begin
                id_o = id_i[l];
            end
        end
    end
endmodule

// File: rtl/prio_group_scan.sv
module prio_group_scan
    import prio_pkg::*;
#(
    parameter int NUM_SRC = 40,
    parameter int LANES   = 4
) (
    input  logic [NUM_SRC-1:0]         pend_i,
    input  logic [NUM_SRC-1:0]         level_i,
    input  logic [LANES-1:0]           lane_vld_i,
    input  logic [LANES-1:0][ID_W-1:0] lane_id_i,
    output logic                       fiq_any_o,
    output logic [ID_W-1:0]            fiq_id_o,
    output logic                       irq_any_o,
    output logic [ID_W-1:0]            irq_id_o
);
    logic [LANES-1:0] fiq_hit;
    logic [LANES-1:0] irq_hit;

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        prio_slot_eval #(.NUM_SRC(NUM_SRC)) u_eval (
            .vld_i     (lane_vld_i[l]),
            .id_i      (lane_id_i[l]),
            .pend_i    (pend_i),
            .level_i   (level_i),
            .fiq_hit_o (fiq_hit[l]),
            .irq_hit_o (irq_hit[l])
        );
    end

    prio_lane_pick #(.LANES(LANES)) u_pick_fiq (
        .hit_i (fiq_hit),
        .id_i  (lane_id_i),
        .any_o (fiq_any_o),
        .id_o  (fiq_id_o)
    );

    prio_lane_pick #(.LANES(LANES)) u_pick_irq (
        .hit_i (irq_hit),
        .id_i  (lane_id_i),
        .any_o (irq_any_o),
        .id_o  (irq_id_o)
    );
endmodule

// File: rtl/prio_resolver.sv
module prio_resolver
    import prio_pkg::*;
#(
    parameter int NUM_SRC  = 40,
    parameter int NUM_SLOT = 40,
    parameter int LANES    = 4
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       start_i,
    input  logic [NUM_SRC-1:0]         pend_i,
    input  logic [NUM_SRC-1:0]         level_i,
    input  logic [NUM_SLOT*SLOT_W-1:0] slot_i,
    output logic                       busy_o,
    output logic                       done_o,
    output logic [STATUS_W-1:0]        status_o
);
    localparam int NGROUP  = (NUM_SLOT + LANES - 1) / LANES;
    localparam int GRP_W   = (NGROUP > 1) ? $clog2(NGROUP) : 1;
    localparam int NPAD    = NGROUP * LANES;
    localparam int SPARE_W = SLOT_W - ID_W - 1;
    localparam logic [GRP_W-1:0] LAST_GRP = GRP_W'(NGROUP - 1);

    typedef struct packed {
        logic                      busy;
        logic                      done;
        logic [GRP_W-1:0]          grp;
        logic [NUM_SRC-1:0]        pend;
        logic [NUM_SRC-1:0]        level;
        logic [NPAD-1:0]           vld;
        logic [NPAD-1:0][ID_W-1:0] id;
        logic                      fiq_hit;
        logic [ID_W-1:0]           fiq_id;
        logic                      irq_hit;
        logic [ID_W-1:0]           irq_id;
        logic [STATUS_W-1:0]       status;
    } state_t;

    state_t state_d, state_q;

    // Compact capture view of the slot table (valid flag and ID only).
    logic [NPAD-1:0]              cap_vld;
    logic [NPAD-1:0][ID_W-1:0]    cap_id;
    logic [NUM_SLOT*SPARE_W-1:0]  unused_slot_bits;

    for (genvar s = 0; s < NPAD; s++) begin : g_cap
        if (s < NUM_SLOT) begin : g_real
            assign cap_vld[s] = slot_i[s*SLOT_W + SLOT_VLD_BIT];
            assign cap_id[s]  = slot_i[s*SLOT_W +: ID_W];
            assign unused_slot_bits[s*SPARE_W +: SPARE_W] =
                slot_i[s*SLOT_W + ID_W +: SPARE_W];
        end else begin : g_pad
            assign cap_vld[s] = 1'b0;
            assign cap_id[s]  = NO_ID;
        end
    end

    // Lanes of the group under scan.
    logic [LANES-1:0]           lane_vld;
    logic [LANES-1:0][ID_W-1:0] lane_id;

    always_comb begin
        int base;
        base = int'(state_q.grp) * LANES;
        for (int l = 0; l < LANES; l++) begin
            lane_vld[l] = state_q.vld[base + l];
            lane_id[l]  = state_q.id[base + l];
        end
    end

    logic            grp_fiq_any, grp_irq_any;
    logic [ID_W-1:0] grp_fiq_id, grp_irq_id;

    prio_group_scan #(.NUM_SRC(NUM_SRC), .LANES(LANES)) u_scan (
        .pend_i     (state_q.pend),
        .level_i    (state_q.level),
        .lane_vld_i (lane_vld),
        .lane_id_i  (lane_id),
        .fiq_any_o  (grp_fiq_any),
        .fiq_id_o   (grp_fiq_id),
        .irq_any_o  (grp_irq_any),
        .irq_id_o   (grp_irq_id)
    );

    always_comb begin
        state_d      = state_q;
        state_d.done = 1'b0;
        if (!state_q.busy) begin
            if (start_i) begin
                state_d.busy    = 1'b1;
                state_d.grp     = '0;
                state_d.pend    = pend_i;
                state_d.level   = level_i;
                state_d.vld     = cap_vld;
                state_d.id      = cap_id;
                state_d.fiq_hit = 1'b0;
                state_d.fiq_id  = NO_ID;
                state_d.irq_hit = 1'b0;
                state_d.irq_id  = NO_ID;
            end
        end else begin
            // Earlier groups hold higher rank: first find in a class sticks.
            if (!state_q.fiq_hit && grp_fiq_any) begin
                state_d.fiq_hit = 1'b1;
                state_d.fiq_id  = grp_fiq_id;
            end
            if (!state_q.irq_hit && grp_irq_any) begin
                state_d.irq_hit = 1'b1;
                state_d.irq_id  = grp_irq_id;
            end
            if (state_q.grp == LAST_GRP) begin
                state_d.busy   = 1'b0;
                state_d.done   = 1'b1;
                state_d.status = pack_status(state_d.fiq_hit, state_d.fiq_id,
                                             state_d.irq_hit, state_d.irq_id);
            end else begin
                state_d.grp = state_q.grp + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q         <= '0;
            state_q.id      <= '1;
            state_q.fiq_id  <= NO_ID;
            state_q.irq_id  <= NO_ID;
            state_q.status  <= IDLE_STATUS;
        end else begin
            state_q <= state_d;
        end
    end

    assign busy_o   = state_q.busy;
    assign done_o   = state_q.done;
    assign status_o = state_q.status;
endmodule

// File: rtl/prio_resolver_chk.sv
module prio_resolver_chk #(
    parameter int NUM_SRC  = 40,
    parameter int NUM_SLOT = 40,
    parameter int LANES    = 4
) (
    input logic        clk,
    input logic        rst_n,
    input logic        start_i,
    input logic        busy_o,
    input logic        done_o,
    input logic [31:0] status_o
);
    localparam int NGROUP = (NUM_SLOT + LANES - 1) / LANES;

    logic [15:0] busy_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            busy_cnt <= '0;
        end else if (busy_o) begin
            busy_cnt <= busy_cnt + 16'd1;
        end else begin
            busy_cnt <= '0;
        end
    end

    AST_START_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !busy_o) |=> busy_o); // R1
    AST_SCAN_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (busy_cnt == 16'(NGROUP))); // R1
    AST_ID_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        status_o[15] |-> (int'(status_o[5:0]) < NUM_SRC)); // R2
    AST_SPARE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (status_o & 32'h7FC0_7FC0) == 32'h0); // R5
    AST_FIQ_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        !status_o[15] |-> (status_o[5:0] == 6'h3F)); // R6
    AST_IRQ_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        !status_o[31] |-> (status_o[21:16] == 6'h3F)); // R6
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o); // R7
    AST_STATUS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !done_o |-> $stable(status_o)); // R7
    AST_BUSY_ENDS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && start_i) |=> (busy_o || done_o)); // R8
endmodule

bind prio_resolver prio_resolver_chk #(
    .NUM_SRC  (NUM_SRC),
    .NUM_SLOT (NUM_SLOT),
    .LANES    (LANES)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .start_i  (start_i),
    .busy_o   (busy_o),
    .done_o   (done_o),
    .status_o (status_o)
);

// File: tb/tb_prio_resolver.sv
module tb_prio_resolver;
    localparam int NSRC  = 40;
    localparam int NSLOT = 40;
    localparam int NLANE = 4;
    localparam int LAT   = (NSLOT + NLANE - 1) / NLANE;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               start_i = 1'b0;
    logic [NSRC-1:0]    pend_i = '0;
    logic [NSRC-1:0]    level_i = '0;
    logic [31:0]        slot_w [NSLOT];
    logic [NSLOT*32-1:0] slot_flat;
    logic               busy_o, done_o;
    logic [31:0]        status_o;

    always #4 clk = ~clk;

    always_comb begin
        for (int s = 0; s < NSLOT; s++) slot_flat[s*32 +: 32] = slot_w[s];
    end

    prio_resolver #(.NUM_SRC(NSRC), .NUM_SLOT(NSLOT), .LANES(NLANE)) dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .pend_i(pend_i),
        .level_i(level_i), .slot_i(slot_flat), .busy_o(busy_o),
        .done_o(done_o), .status_o(status_o)
    );

    typedef struct { logic [31:0] word; int due; string tag; } exp_t;
    exp_t sb[$];

    int total = 0;
    int bad = 0;
    int cyc = 0;
    logic [31:0] last_word = 32'h003F_003F;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", what, act, exp);
        end
    endtask

    // Reference: ascending slot walk, first match per class wins.
    function automatic logic [31:0] model();
        logic fv = 1'b0, iv = 1'b0;
        logic [5:0] fid = 6'h3F, iid = 6'h3F;
        for (int s = 0; s < NSLOT; s++) begin
            logic [5:0] id;
            id = slot_w[s][5:0];
            if (slot_w[s][31] && int'(id) < NSRC && pend_i[id]) begin
                if (level_i[id]) begin
                    if (!fv) begin fv = 1'b1; fid = id; end
                end else begin
                    if (!iv) begin iv = 1'b1; iid = id; end
                end
            end
        end
        return {iv, 9'd0, iid, fv, 9'd0, fid};
    endfunction

    // Monitor: pops expected results on done, checks hold otherwise.
    always @(negedge clk) begin
        if (rst_n) begin
            if (done_o) begin
                if (sb.size() == 0) begin
                    check(1'b0, "R8 done without an accepted start", 32'(done_o), 32'd0);
                end else begin
                    exp_t e;
                    e = sb.pop_front();
                    check(status_o == e.word, {e.tag, " result"}, status_o, e.word);
                    check(cyc == e.due, {e.tag, " R1 latency"}, 32'(cyc), 32'(e.due));
                    last_word = e.word;
                end
            end else begin
                check(status_o == last_word, "R7 status held between scans", status_o, last_word);
            end
        end
    end

    task automatic launch(input string tag);
        exp_t e;
        e.word = model();
        e.due  = cyc + 1 + LAT;
        e.tag  = tag;
        sb.push_back(e);
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        check(busy_o == 1'b1, {tag, " R1 busy after start"}, 32'(busy_o), 32'd1);
    endtask

    task automatic drain();
        while (sb.size() != 0) @(negedge clk);
        @(negedge clk);
    endtask

    task automatic run(input string tag);
        launch(tag);
        drain();
    endtask

    task automatic set_identity();
        for (int s = 0; s < NSLOT; s++) slot_w[s] = {1'b1, 25'd0, 6'(s)};
    endtask

    task automatic set_reversed();
        for (int s = 0; s < NSLOT; s++) slot_w[s] = {1'b1, 25'd0, 6'(NSLOT - 1 - s)};
    endtask

    task automatic randomize_inputs();
        pend_i  = {8'($urandom), $urandom};
        level_i = {8'($urandom), $urandom};
        for (int s = 0; s < NSLOT; s++) begin
            slot_w[s] = $urandom;
            if (($urandom % 4) != 0) slot_w[s][31] = 1'b1;
        end
    endtask

    initial begin
        for (int s = 0; s < NSLOT; s++) slot_w[s] = '0;
        repeat (3) @(negedge clk);
        check(status_o == 32'h003F_003F, "R6 reset status", status_o, 32'h003F_003F);
        check(busy_o == 1'b0 && done_o == 1'b0, "R7 reset strobes", {busy_o, done_o}, 32'd0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check(status_o == 32'h003F_003F, "R6 status after reset", status_o, 32'h003F_003F);

        // R2: all slots invalid, everything pending
        pend_i = '1; level_i = 40'h55_5555_5555;
        run("R2 all slots invalid");

        // R6: identity table but nothing pending
        set_identity(); pend_i = '0;
        run("R6 no pending");

        // R3/R5: single FIQ, single IRQ, both
        pend_i = 40'h1 << 7; level_i = 40'h1 << 7;
        run("R3 single FIQ 7");
        pend_i = 40'h1 << 12; level_i = '0;
        run("R3 single IRQ 12");
        pend_i = (40'h1 << 3) | (40'h1 << 20); level_i = 40'h1 << 20;
        run("R5 FIQ 20 and IRQ 3");
        pend_i = (40'h1 << 39) | 40'h1; level_i = 40'h1;
        run("R5 edge sources 0 and 39");

        // R4: reversed rank order picks highest index
        set_reversed(); pend_i = (40'h1 << 5) | (40'h1 << 30); level_i = '0;
        run("R4 reversed table");

        // R2: invalid flag, out-of-range IDs, junk in spare bits
        set_identity();
        slot_w[0] = {1'b1, 25'd0, 6'd40};
        slot_w[1] = {1'b1, 25'd0, 6'd63};
        slot_w[2] = {1'b0, 25'd0, 6'd9};
        slot_w[3] = {1'b1, 25'h1FF_FFFF, 6'd9};
        slot_w[9] = {1'b0, 25'd0, 6'd9};
        pend_i = (40'h1 << 9) | (40'h1 << 30); level_i = 40'h1 << 30;
        run("R2 skipped slots and spare bits");

        // R4: duplicate source in two slots
        set_identity();
        slot_w[0] = {1'b1, 25'd0, 6'd17};
        slot_w[5] = {1'b1, 25'd0, 6'd17};
        slot_w[1] = {1'b1, 25'd0, 6'd2};
        pend_i = (40'h1 << 17) | (40'h1 << 2); level_i = '0;
        run("R4 duplicate slot lower wins");

        // R1 capture + R8 start during scan with scrambled inputs
        set_identity(); pend_i = 40'h1 << 25; level_i = 40'h1 << 25;
        launch("R1 capture then scramble");
        @(negedge clk);
        randomize_inputs();
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        randomize_inputs();
        drain();
        repeat (LAT + 5) @(negedge clk);
        check(busy_o == 1'b0, "R8 no restart after ignored start", 32'(busy_o), 32'd0);

        // Random cases, including back-to-back starts
        for (int n = 0; n < 30; n++) begin
            randomize_inputs();
            run("R4 random table");
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog expired actual=%0d expected=finish", cyc);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule